// File: doc/BRIEF.md
# PC Serial Port Register and Interrupt Front End

This block is the processor-facing side of a classic PC-compatible serial port controller. A host reaches its registers through a 3-bit offset, separate read and write strobes and byte-wide data buses. Behind that interface sit the transmit and receive data paths, the divisor bytes, line and modem control, line and modem status, a scratch byte and a FIFO control bit. The block ranks four interrupt causes by priority, reports the winning cause as a code in the identification register, and drives a level interrupt line that the modem control output-2 bit gates.

Received bytes arrive on a byte strobe and queue in a 256-entry receive FIFO. Bytes written to the data register leave on a one-cycle transmit strobe. Several registers change state when they are read: reading the receive buffer pops the FIFO, reading the identification register can retire a transmit interrupt, and reading the line or modem status register retires that register's interrupt and updates its flags. An internal loopback mode feeds the modem control outputs back into the modem status inputs, with change flags, and routes transmitted bytes into the receive FIFO.

Bit-level serialisation, baud generation and DMA are outside this block. The divisor bytes are only stored here, for use elsewhere.

Top module: `pc_uart_regs`

## Requirements
- R1: After reset the identification register (offset 2) reads 0x01, the line status register (offset 5) reads 0x60, and `irq` is low.
- R2: While line control bit 7 is 1, offset 0 reads and writes the divisor low byte and offset 1 the divisor high byte. Such writes produce no transmit strobe, push nothing into the FIFO and leave the interrupt enable register unchanged.
- R3: Only bits 3:0 of the interrupt enable register (offset 1, divisor select clear) can be written, and bits 7:4 read 0. The line control (offset 3) and scratch (offset 7) registers read back what was written.
- R4: A receive strobe pushes a byte into a 256-entry FIFO whose pointers wrap modulo 256, and it sets line status bit 0 (data ready). A read of offset 0 returns the oldest byte and pops it. Data ready and the receive interrupt stay set while bytes remain and clear when the FIFO becomes empty. Bytes come out in arrival order across the pointer wrap.
- R5: Interrupt enable bit 2 enables line status, bit 0 receive data, bit 1 transmit empty and bit 3 modem status. Among the enabled pending causes, the identification code is 0x06 for line status, 0x04 for receive data, 0x02 for transmit empty and 0x00 for modem status, in that priority order. It is 0x01 when no enabled cause is pending.
- R6: A read of the identification register that returns code 0x02 clears the pending transmit interrupt. While FIFO control bit 0 (written at offset 2) is 1, the read value has bits 7:6 set.
- R7: A read of line status clears the pending line status interrupt and sets bit 5 (holding empty). It also sets bit 6 (transmitter empty) if bit 5 was already set. A line status write stores the byte: bit 0 raises the receive interrupt, and any of bits 4:1 raise the line status interrupt.
- R8: A read of modem status (offset 6) returns the stored value, then clears bits 3:0 and the pending modem status interrupt. A modem status write with any of bits 3:0 set raises that interrupt.
- R9: `irq` is high exactly when an enabled interrupt is pending and modem control bit 3 (output 2) is 1.
- R10: A data write (offset 0, divisor select clear) pulses `tx_valid` for one cycle on the next clock with `tx_byte` equal to the written byte. It also sets line status bit 5 and raises the transmit interrupt.
- R11: In loopback (modem control bit 4) a modem control write maps control bits 3,2,1,0 onto status bits 7,6,4,5. It sets delta bit 0, 1 or 3 when status bit 4, 5 or 7 changes, and bit 2 when status bit 6 falls. Data writes are copied into the FIFO, and the receive strobe is ignored.
- R12: A receive strobe in the same cycle as a receive buffer read leaves data ready set and the new byte queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; side effects apply at the clock edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current offset, valid in the strobe cycle |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | One-cycle transmit byte strobe |
| tx_byte | output | 8 | Transmitted byte |
| irq | output | 1 | Level interrupt request |

## Verification
A receive byte can land in the same cycle that the host reads the receive buffer: the pop tries to clear data ready while the push tries to set it. The bench asserts the read strobe and the receive strobe on the same clock edge with one byte already queued. It checks that the read returns the older byte, that line status bit 0 is still 1 afterwards, and that the next read returns the newer byte and then leaves data ready clear. The priority scenario is similar: four causes are pending together, and each retiring read must expose the next code in order.

// File: rtl/pcu_pkg.sv
// Shared constants for the serial port register front end: register
// offsets, bit positions, interrupt source indices and their codes.
package pcu_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;

    // Register offsets
    localparam logic [ADDR_W-1:0] OFS_DATA = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_IEN  = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_IDF  = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_LCTL = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_MCTL = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_LSTS = 3'd5;
    localparam logic [ADDR_W-1:0] OFS_MSTS = 3'd6;
    localparam logic [ADDR_W-1:0] OFS_SCR  = 3'd7;

    // Bit positions
    localparam int LC_DIVSEL  = 7;
    localparam int MC_OUT2    = 3;
    localparam int MC_LOOP    = 4;
    localparam int LS_DREADY  = 0;
    localparam int LS_HEMPTY  = 5;
    localparam int LS_TEMPTY  = 6;

    // Interrupt sources, index 0 has highest priority
    localparam int NSRC   = 4;
    localparam int SRC_LS = 0;
    localparam int SRC_RX = 1;
    localparam int SRC_TX = 2;
    localparam int SRC_MS = 3;

    localparam logic [3:0] CODE_NONE = 4'h1;

    // Identification code for a given source index
    function automatic logic [3:0] src_code(input int idx);
        case (idx)
            SRC_LS:  src_code = 4'h6;
            SRC_RX:  src_code = 4'h4;
            SRC_TX:  src_code = 4'h2;
            default: src_code = 4'h0;
        endcase
    endfunction

endpackage

// File: rtl/pcu_rx_fifo.sv
// Receive byte queue for the serial port front end.
// Assumes DEPTH is a power of two so that the pointers wrap naturally.
// There is no overflow guard: a push into a full queue wraps the write
// pointer onto the read pointer.
module pcu_rx_fifo #(
    parameter int DEPTH = 256,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             last_one
);
    localparam int PW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr;
    logic [PW-1:0]    rd_ptr;

    // Store the pushed byte at the write pointer
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    // Advance both pointers, modulo DEPTH
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop && !empty) rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // Occupancy flags and the oldest entry
    always_comb begin
        empty    = (rd_ptr == wr_ptr);
        last_one = ((rd_ptr + 1'b1) == wr_ptr);
        head     = mem[rd_ptr];
    end

endmodule

// File: rtl/pcu_irq_prio.sv
// Fixed-priority interrupt arbiter: picks the highest-priority enabled
// pending source, returns its identification code and drives the level
// request gated by the output-2 control bit.
// Assumes source index 0 is the highest priority.
module pcu_irq_prio
    import pcu_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0] pend,
    input  logic [N-1:0] en,
    input  logic         out2,
    output logic [3:0]   iid,
    output logic         irq
);
    // Scan from lowest to highest priority so the highest wins
    always_comb begin
        iid = CODE_NONE;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i] && en[i]) iid = src_code(i);
        end
    end

    // Level request only when output 2 is set
    always_comb irq = (|(pend & en)) && out2;

endmodule

// File: rtl/pcu_modem_loop.sv
// Loopback modem status builder: maps modem control outputs onto the
// status inputs and merges change flags with the ones still unread.
// Purely combinational; the caller decides when to load the result.
module pcu_modem_loop (
    input  logic [7:0] msr_old,
    input  logic [4:0] mcr_new,
    output logic [7:0] msr_new
);
    logic cts, dsr, ri, dcd;

    // Build status lines and delta flags
    always_comb begin
        cts = mcr_new[1];
        dsr = mcr_new[0];
        ri  = mcr_new[2];
        dcd = mcr_new[3];
        msr_new      = {dcd, ri, dsr, cts, msr_old[3:0]};
        if (msr_old[4] != cts) msr_new[0] = 1'b1;
        if (msr_old[5] != dsr) msr_new[1] = 1'b1;
        if (msr_old[6] && !ri) msr_new[2] = 1'b1;
        if (msr_old[7] != dcd) msr_new[3] = 1'b1;
    end

endmodule

// File: rtl/pc_uart_regs.sv
// Register front end of a PC-style serial port controller.
// Holds the host-visible registers, the receive queue and the interrupt
// logic. Read side effects take place at the clock edge of the read
// strobe cycle; rdata is combinational from the current state.
// Assumes wr_en and rd_en are never high in the same cycle.
module pc_uart_regs
    import pcu_pkg::*;
#(
    parameter int RX_DEPTH = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_byte,
    output logic              irq
);
    localparam logic [7:0] LSR_RST = 8'h60;

    logic [7:0]      div_lo_q, div_hi_q, lcr_q, lsr_q, msr_q, scr_q, hold_q;
    logic [3:0]      ier_q;
    logic [4:0]      mcr_q;
    logic            fen_q;
    logic [NSRC-1:0] pend_q, pend_d, src_en;
    logic [7:0]      lsr_d, msr_d, msr_lb;
    logic [3:0]      iid;
    logic            divsel, loop_on;
    logic            wr_thr, rd_rbr, rd_iid, rd_lsr, rd_msr, wr_lsr, wr_msr, wr_mcr;
    logic            push, pop, q_empty, q_last;
    logic [7:0]      push_byte, q_head;

    // Access decode
    always_comb begin
        divsel  = lcr_q[LC_DIVSEL];
        loop_on = mcr_q[MC_LOOP];
        wr_thr  = wr_en && (addr == OFS_DATA) && !divsel;
        rd_rbr  = rd_en && (addr == OFS_DATA) && !divsel;
        rd_iid  = rd_en && (addr == OFS_IDF);
        rd_lsr  = rd_en && (addr == OFS_LSTS);
        rd_msr  = rd_en && (addr == OFS_MSTS);
        wr_lsr  = wr_en && (addr == OFS_LSTS);
        wr_msr  = wr_en && (addr == OFS_MSTS);
        wr_mcr  = wr_en && (addr == OFS_MCTL);
    end

    // Queue input selection: echo in loopback, line input otherwise
    always_comb begin
        push      = loop_on ? wr_thr : rx_valid;
        push_byte = loop_on ? wdata  : rx_byte;
        pop       = rd_rbr && !q_empty;
    end

    pcu_rx_fifo #(.DEPTH(RX_DEPTH), .WIDTH(DATA_W)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_data(push_byte),
        .pop(pop), .head(q_head),
        .empty(q_empty), .last_one(q_last)
    );

    // Map enable bits onto priority-ordered source slots
    always_comb begin
        src_en         = '0;
        src_en[SRC_LS] = ier_q[2];
        src_en[SRC_RX] = ier_q[0];
        src_en[SRC_TX] = ier_q[1];
        src_en[SRC_MS] = ier_q[3];
    end

    pcu_irq_prio #(.N(NSRC)) u_prio (
        .pend(pend_q), .en(src_en), .out2(mcr_q[MC_OUT2]),
        .iid(iid), .irq(irq)
    );

    pcu_modem_loop u_mloop (
        .msr_old(msr_q), .mcr_new(wdata[4:0]), .msr_new(msr_lb)
    );

    // Next state of line status, modem status and pending causes
    always_comb begin
        lsr_d  = lsr_q;
        msr_d  = msr_q;
        pend_d = pend_q;
        if (wr_lsr) begin
            lsr_d = wdata;
            if (wdata[LS_DREADY]) pend_d[SRC_RX] = 1'b1;
            if (|wdata[4:1])      pend_d[SRC_LS] = 1'b1;
        end
        if (wr_thr) begin
            lsr_d[LS_HEMPTY] = 1'b1;
            pend_d[SRC_TX]   = 1'b1;
        end
        if (rd_lsr) begin
            lsr_d[LS_TEMPTY] = lsr_q[LS_TEMPTY] | lsr_q[LS_HEMPTY];
            lsr_d[LS_HEMPTY] = 1'b1;
            pend_d[SRC_LS]   = 1'b0;
        end
        if (rd_iid && (iid == src_code(SRC_TX))) pend_d[SRC_TX] = 1'b0;
        if (rd_rbr) begin
            lsr_d[LS_DREADY] = !q_empty && !q_last;
            pend_d[SRC_RX]   = !q_empty && !q_last;
        end
        if (push) begin
            if (!lsr_q[LS_DREADY] || rd_rbr) pend_d[SRC_RX] = 1'b1;
            lsr_d[LS_DREADY] = 1'b1;
        end
        if (wr_msr) begin
            msr_d = wdata;
            if (|wdata[3:0]) pend_d[SRC_MS] = 1'b1;
        end
        if (wr_mcr && wdata[MC_LOOP]) begin
            msr_d = msr_lb;
            if (|msr_lb[3:0]) pend_d[SRC_MS] = 1'b1;
        end
        if (rd_msr) begin
            msr_d[3:0]     = 4'h0;
            pend_d[SRC_MS] = 1'b0;
        end
    end

    // Status and pending registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lsr_q  <= LSR_RST;
            msr_q  <= '0;
            pend_q <= '0;
        end else begin
            lsr_q  <= lsr_d;
            msr_q  <= msr_d;
            pend_q <= pend_d;
        end
    end

    // Host-written control registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_lo_q <= '0;
            div_hi_q <= '0;
            ier_q    <= '0;
            lcr_q    <= '0;
            mcr_q    <= '0;
            scr_q    <= '0;
            fen_q    <= 1'b0;
        end else if (wr_en) begin
            case (addr)
                OFS_DATA: if (divsel) div_lo_q <= wdata;
                OFS_IEN:  if (divsel) div_hi_q <= wdata; else ier_q <= wdata[3:0];
                OFS_IDF:  fen_q <= wdata[0];
                OFS_LCTL: lcr_q <= wdata;
                OFS_MCTL: mcr_q <= wdata[4:0];
                OFS_SCR:  scr_q <= wdata;
                default:  ;
            endcase
        end
    end

    // Last popped byte, returned when the queue is empty
    always_ff @(posedge clk) begin
        if (!rst_n)   hold_q <= '0;
        else if (pop) hold_q <= q_head;
    end

    // Transmit strobe one cycle after a data write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_byte  <= '0;
        end else begin
            tx_valid <= wr_thr;
            if (wr_thr) tx_byte <= wdata;
        end
    end

    // Read data multiplexer
    always_comb begin
        case (addr)
            OFS_DATA: rdata = divsel ? div_lo_q : (q_empty ? hold_q : q_head);
            OFS_IEN:  rdata = divsel ? div_hi_q : {4'h0, ier_q};
            OFS_IDF:  rdata = {fen_q, fen_q, 2'b00, iid};
            OFS_LCTL: rdata = lcr_q;
            OFS_MCTL: rdata = {3'b000, mcr_q};
            OFS_LSTS: rdata = lsr_q;
            OFS_MSTS: rdata = msr_q;
            default:  rdata = scr_q;
        endcase
    end

endmodule

// File: rtl/pcu_regs_chk.sv
// Property checker for the serial port register front end, bound into
// the top module. Observes ports and a few state registers.
module pcu_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] addr,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic       irq,
    input logic       tx_valid,
    input logic [7:0] tx_byte,
    input logic       out2,
    input logic       divsel,
    input logic [3:0] iid,
    input logic [7:0] msr,
    input logic [7:0] lsr
);
    p_irq_needs_out2_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> out2);

    p_irq_has_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (iid[0] == 1'b0));

    p_tx_follows_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && addr == 3'd0 && !divsel) |=> (tx_valid && tx_byte == $past(wdata)));

    p_no_stray_tx_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == 3'd0 && !divsel) |=> !tx_valid);

    p_msr_deltas_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr == 3'd6) |=> (msr[3:0] == 4'h0));

    p_lsr_read_hempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr == 3'd5) |=> lsr[5]);

    p_ier_high_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 3'd1 && !divsel) |-> (rdata[7:4] == 4'h0));

endmodule

bind pc_uart_regs pcu_regs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq(irq), .tx_valid(tx_valid),
    .tx_byte(tx_byte), .out2(mcr_q[3]), .divsel(lcr_q[7]), .iid(iid),
    .msr(msr_q), .lsr(lsr_q)
);

// File: tb/tb_pc_uart_regs.sv
`timescale 1ns/1ps
module tb_pc_uart_regs;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0, rx_valid = 1'b0;
    logic [7:0] wdata = '0, rx_byte = '0;
    logic [7:0] rdata, tx_byte;
    logic       tx_valid, irq;

    int   n_chk = 0, n_err = 0;
    bit   done = 1'b0;
    logic last_tx_v;
    logic [7:0] last_tx_b;

    always #10 clk = ~clk;

    pc_uart_regs dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        last_tx_v = tx_valid; last_tx_b = tx_byte;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk); addr = a; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic rx(input logic [7:0] d);
        @(negedge clk); rx_valid = 1'b1; rx_byte = d;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(3'd2, v); chk("R1 iid", v, 8'h01);
        rd(3'd5, v); chk("R1 lsr", v, 8'h60);
        chk("R1 irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_divisor();
        logic [7:0] v;
        wr(3'd3, 8'h83);
        wr(3'd0, 8'h34); chk("R2 no tx", {7'd0, last_tx_v}, 8'h00);
        wr(3'd1, 8'h12);
        rd(3'd0, v); chk("R2 div lo", v, 8'h34);
        rd(3'd1, v); chk("R2 div hi", v, 8'h12);
        wr(3'd3, 8'h03);
        rd(3'd1, v); chk("R2 ier kept", v, 8'h00);
        rd(3'd5, v); chk("R2 no push", v & 8'h01, 8'h00);
    endtask

    task automatic t_plain_regs();
        logic [7:0] v;
        wr(3'd1, 8'hFF); rd(3'd1, v); chk("R3 ier mask", v, 8'h0F);
        wr(3'd1, 8'h00);
        wr(3'd7, 8'hA5); rd(3'd7, v); chk("R3 scratch", v, 8'hA5);
        rd(3'd3, v); chk("R3 lcr", v, 8'h03);
    endtask

    task automatic t_transmit();
        logic [7:0] v;
        wr(3'd5, 8'h00);
        wr(3'd0, 8'hC3);
        chk("R10 tx strobe", {7'd0, last_tx_v}, 8'h01);
        chk("R10 tx byte", last_tx_b, 8'hC3);
        rd(3'd5, v); chk("R10 hempty set", v, 8'h20);
        rd(3'd2, v); chk("R5 disabled", v, 8'h01);
        wr(3'd1, 8'h02);
        rd(3'd2, v); chk("R6 tx code", v, 8'h02);
        rd(3'd2, v); chk("R6 tx cleared", v, 8'h01);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_line_status();
        logic [7:0] v;
        wr(3'd5, 8'h00);
        rd(3'd5, v); chk("R7 first", v, 8'h00);
        rd(3'd5, v); chk("R7 hempty", v, 8'h20);
        rd(3'd5, v); chk("R7 tempty", v, 8'h60);
        wr(3'd1, 8'h04);
        wr(3'd5, 8'h62);
        rd(3'd2, v); chk("R7 ls code", v, 8'h06);
        rd(3'd5, v); chk("R7 ls read", v, 8'h62);
        rd(3'd2, v); chk("R7 ls cleared", v, 8'h01);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_fifo();
        logic [7:0] v;
        wr(3'd1, 8'h01);
        rx(8'h9E);
        rd(3'd2, v); chk("R4 rx code", v, 8'h04);
        rd(3'd0, v); chk("R4 single", v, 8'h9E);
        rd(3'd2, v); chk("R4 rx cleared", v, 8'h01);
        wr(3'd1, 8'h00);
        for (int i = 0; i < 200; i++) rx(8'((i * 7 + 1) & 8'hFF));
        rd(3'd5, v); chk("R4 dready", v & 8'h01, 8'h01);
        for (int i = 0; i < 200; i++) begin
            rd(3'd0, v); chk("R4 order", v, 8'((i * 7 + 1) & 8'hFF));
            if (i == 198) begin
                rd(3'd5, v); chk("R4 dready remains", v & 8'h01, 8'h01);
            end
        end
        rd(3'd5, v); chk("R4 empty", v & 8'h01, 8'h00);
        for (int i = 0; i < 100; i++) rx(8'(i ^ 8'h5C));
        for (int i = 0; i < 100; i++) begin
            rd(3'd0, v); chk("R4 wrap order", v, 8'(i ^ 8'h5C));
        end
        rd(3'd5, v); chk("R4 wrap empty", v & 8'h01, 8'h00);
    endtask

    task automatic t_priority();
        logic [7:0] v;
        wr(3'd1, 8'h0F);
        wr(3'd0, 8'h11);
        rx(8'h22);
        wr(3'd5, 8'h63);
        wr(3'd6, 8'h01);
        rd(3'd2, v); chk("R5 ls first", v, 8'h06);
        rd(3'd5, v); chk("R7 lsr value", v, 8'h63);
        rd(3'd2, v); chk("R5 rx second", v, 8'h04);
        rd(3'd0, v); chk("R4 rx byte", v, 8'h22);
        rd(3'd2, v); chk("R5 tx third", v, 8'h02);
        rd(3'd2, v); chk("R5 ms last", v, 8'h00);
        rd(3'd6, v); chk("R8 msr read", v, 8'h01);
        rd(3'd6, v); chk("R8 deltas cleared", v, 8'h00);
        rd(3'd2, v); chk("R8 ms cleared", v, 8'h01);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_irq_gate();
        logic [7:0] v;
        wr(3'd1, 8'h02);
        wr(3'd0, 8'h33);
        chk("R9 gated low", {7'd0, irq}, 8'h00);
        wr(3'd4, 8'h08);
        chk("R9 high", {7'd0, irq}, 8'h01);
        rd(3'd2, v);
        chk("R9 low after clear", {7'd0, irq}, 8'h00);
        wr(3'd4, 8'h00);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_fifo_bits();
        logic [7:0] v;
        wr(3'd2, 8'h01);
        rd(3'd2, v); chk("R6 fifo bits", v, 8'hC1);
        wr(3'd2, 8'h00);
        rd(3'd2, v); chk("R6 fifo bits off", v, 8'h01);
    endtask

    task automatic t_loopback();
        logic [7:0] v;
        wr(3'd6, 8'h00);
        wr(3'd4, 8'h10);
        rd(3'd6, v); chk("R11 idle", v, 8'h00);
        wr(3'd4, 8'h1F);
        rd(3'd6, v); chk("R11 rise deltas", v, 8'hFB);
        rd(3'd6, v); chk("R11 after read", v, 8'hF0);
        wr(3'd4, 8'h1B);
        rd(3'd6, v); chk("R11 ring fall", v, 8'hB4);
        wr(3'd0, 8'h5A);
        chk("R11 tx too", {7'd0, last_tx_v}, 8'h01);
        rx(8'h77);
        rd(3'd0, v); chk("R11 echo", v, 8'h5A);
        rd(3'd5, v); chk("R11 rx ignored", v & 8'h01, 8'h00);
        wr(3'd4, 8'h00);
        wr(3'd6, 8'h00);
    endtask

    task automatic t_same_cycle();
        logic [7:0] v;
        rx(8'h41);
        @(negedge clk); addr = 3'd0; rd_en = 1'b1; rx_valid = 1'b1; rx_byte = 8'h42;
        #1 v = rdata;
        @(negedge clk); rd_en = 1'b0; rx_valid = 1'b0;
        chk("R12 older byte", v, 8'h41);
        rd(3'd5, v); chk("R12 dready kept", v & 8'h01, 8'h01);
        rd(3'd0, v); chk("R12 newer byte", v, 8'h42);
        rd(3'd5, v); chk("R12 drained", v & 8'h01, 8'h00);
    endtask

    initial begin : watchdog
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        n_chk++; n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_divisor();
        t_plain_regs();
        t_transmit();
        t_line_status();
        t_fifo();
        t_priority();
        t_irq_gate();
        t_fifo_bits();
        t_loopback();
        t_same_cycle();
        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule